// File: doc/BRIEF.md
# Switching Fault and Auto-Restart Supervisor

This block collects the protection flags of an off-line switching controller and turns them into a single permit that tells the cycle controller whether it may start switching cycles. Every flag it receives comes from an analog comparator that lies outside the block and reaches it already digitised: the supply rail upper and lower levels, the line-sense start current, the absence of a line-sense resistor, the thermal trip and recovery flags, and the overvoltage current flag. It also receives the per-cycle feedback-low event and a tick from the oscillator.

Five lockout conditions are held in registers, and each one drives its own status pin. The first is the supply rail hysteresis. The second is the line start gate. The third is a thermal lockout with hysteresis. The fourth is an overvoltage latch that clears only on power-down. The fifth is the auto-restart off phase. A loss-of-feedback timer counts oscillator ticks and starts again from zero on every feedback-low event. When it expires, switching stops for a fixed number of ticks. While the line is under voltage that off period stops counting, so it lasts until the line recovers. Switching is then tried again. The timer lengths are parameters given in oscillator ticks, and the defaults match 64 ms and 2.5 s at 132 kHz.

Top module: `fsup_supervisor`

## Requirements
- R1: After reset, lk_rail and lk_line are 1, lk_thermal, lk_ovp and lk_restart are 0, and sw_permit is 0.
- R2: In the cycle after rail_below_off is high, lk_rail is 1. In the cycle after rail_above_on is high while rail_below_off is low, lk_rail is 0. In every other case lk_rail keeps its value.
- R3: lk_line is set in the cycle after lk_rail was 1 or an off phase ended. In any other case it clears in the cycle after the line is not under voltage. The line counts as under voltage when line_above_start and line_res_absent are both 0.
- R4: temp_over sets lk_thermal in the next cycle. When temp_over is low, temp_recovered clears lk_thermal in the next cycle. Otherwise lk_thermal holds its value.
- R5: ovp_current sets lk_ovp in the next cycle. lk_ovp clears only in the cycle after rail_below_off is high while ovp_current is low.
- R6: While lk_restart is 0, a tick counter runs. fb_low_evt clears it, and so does any of lk_rail, lk_line, lk_thermal or lk_ovp being 1. When the counter reaches WDOG_TICKS ticks with none of these clears in between, lk_restart is 1 in the next cycle.
- R7: While lk_restart is 1, fb_low_evt is ignored. Only ticks that arrive while the line is not under voltage are counted. The off phase ends after OFF_TICKS such ticks, or at once when lk_rail is 1.
- R8: sw_permit is 1 exactly when all five lockout status outputs are 0.
- R9: In the first cycle after an off phase ends, lk_line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| rail_above_on | input | 1 | Supply rail is above its turn-on level |
| rail_below_off | input | 1 | Supply rail is below its turn-off level |
| line_above_start | input | 1 | Line-sense current is above its start threshold |
| line_res_absent | input | 1 | No line-sense resistor is fitted |
| temp_over | input | 1 | Die temperature is above the trip point |
| temp_recovered | input | 1 | Die temperature has fallen by the hysteresis |
| ovp_current | input | 1 | Overvoltage current is above its threshold |
| fb_low_evt | input | 1 | Feedback pulled the enable input low |
| sw_permit | output | 1 | Switching is allowed |
| lk_rail | output | 1 | Supply rail lockout |
| lk_line | output | 1 | Line start gate is closed |
| lk_thermal | output | 1 | Thermal lockout |
| lk_ovp | output | 1 | Overvoltage latch |
| lk_restart | output | 1 | Auto-restart off phase |

## Verification
Each lockout is a registered bit that drives its own status pin. If one of these bits takes a wrong value, the fault shows on that pin and on sw_permit in the very next cycle. A restart counter that drifts has no pin of its own, so it shows up later. lk_restart then rises or falls at least one tick away from the expected cycle. The bench counts ticks without feedback and off ticks outside undervoltage, and it compares every output on every cycle. A counter that is off by even one therefore fails at the first edge of the phase.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic {
        AR_RUN = 1'b0,
        AR_OFF = 1'b1
    } ar_state_e;

    typedef struct packed {
        logic rail_lock;
        logic ovp_lock;
    } rail_state_t;

endpackage

// File: rtl/fsup_rail_guard.sv
module fsup_rail_guard
    import fsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_above_on,
    input  logic rail_below_off,
    input  logic ovp_current,
    output logic rail_lock,
    output logic ovp_lock
);

    rail_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // rail hysteresis: the low level wins over the high level
        if (rail_below_off) begin
            s_d.rail_lock = 1'b1;
        end else if (rail_above_on) begin
            s_d.rail_lock = 1'b0;
        end
        // overvoltage latch: set wins, clear only on power-down
        if (ovp_current) begin
            s_d.ovp_lock = 1'b1;
        end else if (rail_below_off) begin
            s_d.ovp_lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{rail_lock: 1'b1, ovp_lock: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rail_lock = s_q.rail_lock;
    assign ovp_lock  = s_q.ovp_lock;

endmodule

// File: rtl/fsup_thermal.sv
module fsup_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_over,
    input  logic temp_recovered,
    output logic therm_lock
);

    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (temp_over) begin
            lock_d = 1'b1;
        end else if (temp_recovered) begin
            lock_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign therm_lock = lock_q;

endmodule

// File: rtl/fsup_line_gate.sv
module fsup_line_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic line_uv,
    output logic line_wait
);

    logic wait_d, wait_q;

    always_comb begin
        wait_d = wait_q;
        if (arm) begin
            wait_d = 1'b1;
        end else if (!line_uv) begin
            wait_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= 1'b1;
        end else begin
            wait_q <= wait_d;
        end
    end

    assign line_wait = wait_q;

endmodule

// File: rtl/fsup_restart_timer.sv
module fsup_restart_timer
    import fsup_pkg::*;
#(
    parameter int WDOG_TICKS = 8448,
    parameter int OFF_TICKS  = 330000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fb_low,
    input  logic hold_clear,
    input  logic rail_lock,
    input  logic line_uv,
    output logic restart_off,
    output logic off_end
);

    localparam int MAX_TICKS = (WDOG_TICKS > OFF_TICKS) ? WDOG_TICKS : OFF_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] WD_LAST  = CNT_W'(WDOG_TICKS - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);

    typedef struct packed {
        ar_state_e        st;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        off_end = 1'b0;
        case (t_q.st)
            AR_RUN: begin
                if (hold_clear || fb_low) begin
                    t_d.cnt = '0;
                end else if (tick) begin
                    if (t_q.cnt == WD_LAST) begin
                        t_d.st  = AR_OFF;
                        t_d.cnt = '0;
                    end else begin
                        t_d.cnt = t_q.cnt + 1'b1;
                    end
                end
            end
            AR_OFF: begin
                if (rail_lock) begin
                    t_d.st  = AR_RUN;
                    t_d.cnt = '0;
                    off_end = 1'b1;
                end else if (tick && !line_uv) begin
                    if (t_q.cnt == OFF_LAST) begin
                        t_d.st  = AR_RUN;
                        t_d.cnt = '0;
                        off_end = 1'b1;
                    end else begin
                        t_d.cnt = t_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                t_d = '{st: AR_RUN, cnt: '0};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{st: AR_RUN, cnt: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign restart_off = (t_q.st == AR_OFF);

endmodule

// File: rtl/fsup_supervisor.sv
module fsup_supervisor #(
    parameter int WDOG_TICKS = 8448,
    parameter int OFF_TICKS  = 330000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic rail_above_on,
    input  logic rail_below_off,
    input  logic line_above_start,
    input  logic line_res_absent,
    input  logic temp_over,
    input  logic temp_recovered,
    input  logic ovp_current,
    input  logic fb_low_evt,
    output logic sw_permit,
    output logic lk_rail,
    output logic lk_line,
    output logic lk_thermal,
    output logic lk_ovp,
    output logic lk_restart
);

    logic line_uv;
    logic other_lock;
    logic off_end;

    assign line_uv    = !line_above_start && !line_res_absent;
    assign other_lock = lk_rail || lk_line || lk_thermal || lk_ovp;

    fsup_rail_guard u_rail (
        .clk            (clk),
        .rst_n          (rst_n),
        .rail_above_on  (rail_above_on),
        .rail_below_off (rail_below_off),
        .ovp_current    (ovp_current),
        .rail_lock      (lk_rail),
        .ovp_lock       (lk_ovp)
    );

    fsup_thermal u_therm (
        .clk            (clk),
        .rst_n          (rst_n),
        .temp_over      (temp_over),
        .temp_recovered (temp_recovered),
        .therm_lock     (lk_thermal)
    );

    fsup_line_gate u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (lk_rail || off_end),
        .line_uv   (line_uv),
        .line_wait (lk_line)
    );

    fsup_restart_timer #(
        .WDOG_TICKS (WDOG_TICKS),
        .OFF_TICKS  (OFF_TICKS)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (osc_tick),
        .fb_low      (fb_low_evt),
        .hold_clear  (other_lock),
        .rail_lock   (lk_rail),
        .line_uv     (line_uv),
        .restart_off (lk_restart),
        .off_end     (off_end)
    );

    assign sw_permit = !(other_lock || lk_restart);

endmodule

// File: rtl/fsup_supervisor_chk.sv
module fsup_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_tick,
    input logic rail_above_on,
    input logic rail_below_off,
    input logic temp_over,
    input logic ovp_current,
    input logic fb_low_evt,
    input logic sw_permit,
    input logic lk_rail,
    input logic lk_line,
    input logic lk_thermal,
    input logic lk_ovp,
    input logic lk_restart
);

    AST_RAIL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rail_below_off |=> lk_rail); // R2

    AST_RAIL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_above_on && !rail_below_off) |=> !lk_rail); // R2

    AST_RAIL_ARMS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rail |=> lk_line); // R3

    AST_THERM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        temp_over |=> lk_thermal); // R4

    AST_OVP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_current |=> lk_ovp); // R5

    AST_OVP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ovp && !rail_below_off) |=> lk_ovp); // R5

    AST_OFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_restart) |-> ($past(osc_tick) && !$past(fb_low_evt))); // R6

    AST_PERMIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_thermal) |-> !sw_permit); // R8

    AST_OFF_EXIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk_restart) |-> lk_line); // R9

endmodule

bind fsup_supervisor fsup_supervisor_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .osc_tick       (osc_tick),
    .rail_above_on  (rail_above_on),
    .rail_below_off (rail_below_off),
    .temp_over      (temp_over),
    .ovp_current    (ovp_current),
    .fb_low_evt     (fb_low_evt),
    .sw_permit      (sw_permit),
    .lk_rail        (lk_rail),
    .lk_line        (lk_line),
    .lk_thermal     (lk_thermal),
    .lk_ovp         (lk_ovp),
    .lk_restart     (lk_restart)
);

// File: tb/sim_fsup_supervisor.sv
`timescale 1ns/1ps
module sim_fsup_supervisor;

    localparam int WD  = 16;
    localparam int OFF = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 0, rail_above_on = 0, rail_below_off = 0;
    logic line_above_start = 0, line_res_absent = 0;
    logic temp_over = 0, temp_recovered = 0, ovp_current = 0, fb_low_evt = 0;
    logic sw_permit, lk_rail, lk_line, lk_thermal, lk_ovp, lk_restart;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    // reference state
    bit m_rail, m_line, m_th, m_ov, m_off;
    int m_cnt;

    always #2 clk = ~clk;
    always @(posedge clk) cycles++;

    fsup_supervisor #(.WDOG_TICKS(WD), .OFF_TICKS(OFF)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .rail_above_on(rail_above_on), .rail_below_off(rail_below_off),
        .line_above_start(line_above_start), .line_res_absent(line_res_absent),
        .temp_over(temp_over), .temp_recovered(temp_recovered),
        .ovp_current(ovp_current), .fb_low_evt(fb_low_evt),
        .sw_permit(sw_permit), .lk_rail(lk_rail), .lk_line(lk_line),
        .lk_thermal(lk_thermal), .lk_ovp(lk_ovp), .lk_restart(lk_restart)
    );

    function automatic bit exp_permit();
        return !(m_rail || m_line || m_th || m_ov || m_off);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    task automatic model_step();
        bit luv, other, off_end, n_rail, n_ov, n_th, n_line;
        luv     = !line_above_start && !line_res_absent;
        n_rail  = rail_below_off ? 1'b1 : (rail_above_on ? 1'b0 : m_rail);
        n_ov    = ovp_current ? 1'b1 : (rail_below_off ? 1'b0 : m_ov);
        n_th    = temp_over ? 1'b1 : (temp_recovered ? 1'b0 : m_th);
        other   = m_rail || m_ov || m_th || m_line;
        off_end = 1'b0;
        if (!m_off) begin
            if (other || fb_low_evt) m_cnt = 0;
            else if (osc_tick) begin
                if (m_cnt == WD - 1) begin m_off = 1'b1; m_cnt = 0; end
                else m_cnt++;
            end
        end else begin
            if (m_rail) begin m_off = 1'b0; m_cnt = 0; off_end = 1'b1; end
            else if (osc_tick && !luv) begin
                if (m_cnt == OFF - 1) begin m_off = 1'b0; m_cnt = 0; off_end = 1'b1; end
                else m_cnt++;
            end
        end
        n_line = (m_rail || off_end) ? 1'b1 : (!luv ? 1'b0 : m_line);
        m_rail = n_rail; m_ov = n_ov; m_th = n_th; m_line = n_line;
    endtask

    // apply the current inputs for one edge, then compare every output
    task automatic cyc();
        model_step();
        @(negedge clk);
        chk("R8 permit", sw_permit, exp_permit());
        chk("R2 rail", lk_rail, m_rail);
        chk("R3/R9 line", lk_line, m_line);
        chk("R4 thermal", lk_thermal, m_th);
        chk("R5 ovp", lk_ovp, m_ov);
        chk("R6/R7 restart", lk_restart, m_off);
    endtask

    task automatic quiet();
        osc_tick = 0; rail_above_on = 0; rail_below_off = 0;
        temp_over = 0; temp_recovered = 0; ovp_current = 0; fb_low_evt = 1;
        line_above_start = 1; line_res_absent = 0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20250611);
        m_rail = 1; m_line = 1; m_th = 0; m_ov = 0; m_off = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state (no inputs active yet)
        chk("R1 rail", lk_rail, 1'b1);
        chk("R1 line", lk_line, 1'b1);
        chk("R1 thermal", lk_thermal, 1'b0);
        chk("R1 ovp", lk_ovp, 1'b0);
        chk("R1 restart", lk_restart, 1'b0);
        chk("R1 permit", sw_permit, 1'b0);
        model_step(); // the edge just passed with idle inputs

        // power-up with line under voltage: rail releases, line gate stays
        quiet(); line_above_start = 0; rail_above_on = 1;
        cyc(); cyc();
        chk("R3 line held under voltage", lk_line, 1'b1);
        chk("R8 no permit with line gate", sw_permit, 1'b0);
        line_res_absent = 1; cyc();
        chk("R3 bypass with no resistor", lk_line, 1'b0);
        line_res_absent = 0; line_above_start = 1; cyc();
        chk("R8 permit once clear", sw_permit, 1'b1);

        // watchdog expiry
        quiet(); fb_low_evt = 0; osc_tick = 1;
        repeat (WD - 1) cyc();
        chk("R6 not yet expired", lk_restart, 1'b0);
        cyc();
        chk("R6 expired", lk_restart, 1'b1);

        // off phase frozen by line undervoltage, feedback ignored
        line_above_start = 0; fb_low_evt = 1;
        repeat (OFF + 10) cyc();
        chk("R7 stretched by undervoltage", lk_restart, 1'b1);
        line_above_start = 1;
        repeat (OFF - 1) cyc();
        chk("R7 still off", lk_restart, 1'b1);
        cyc();
        chk("R7 off ended", lk_restart, 1'b0);
        chk("R9 line gate armed", lk_line, 1'b1);
        cyc();
        chk("R3 line gate released", lk_line, 1'b0);

        // thermal hysteresis
        quiet(); temp_over = 1; cyc();
        chk("R4 thermal set", lk_thermal, 1'b1);
        temp_over = 0; repeat (3) cyc();
        chk("R4 thermal holds", lk_thermal, 1'b1);
        temp_recovered = 1; cyc();
        chk("R4 thermal recovered", lk_thermal, 1'b0);

        // overvoltage latch survives rail high, clears on power-down
        quiet(); ovp_current = 1; cyc();
        ovp_current = 0; rail_above_on = 1; repeat (3) cyc();
        chk("R5 latch holds", lk_ovp, 1'b1);
        rail_above_on = 0; rail_below_off = 1; cyc();
        chk("R5 cleared on power-down", lk_ovp, 1'b0);
        chk("R2 rail locked", lk_rail, 1'b1);
        rail_below_off = 0; cyc();
        chk("R2 rail holds without either flag", lk_rail, 1'b1);

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom % 100;
            rail_below_off = (r < 2);
            rail_above_on  = (r >= 2 && r < 40);
            osc_tick         = ($urandom % 2) == 0;
            fb_low_evt       = ($urandom % 100) < 8;
            line_above_start = ($urandom % 100) < 75;
            line_res_absent  = ($urandom % 100) < 15;
            temp_over        = ($urandom % 200) == 0;
            temp_recovered   = ($urandom % 100) < 10;
            ovp_current      = ($urandom % 300) == 0;
            cyc();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule